// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is a bus master that turns single requests from inside the chip into read or write cycles on a 16-bit asynchronous bus with two byte lanes. A requester presents a word address, a direction, a byte-lane mask and write data. Once the request is accepted, the block runs a bus cycle built from eight numbered half-clock states, S0 to S7, and then reports completion with read data or an error flag.

The block drives a bus clock, the address with its enable, an address strobe, a read/write line, one strobe per byte lane, and the enable of the write data drivers. It samples a transfer acknowledge and a bus-error input from the addressed slave. Each system clock tick is one half of a bus clock, so a bus clock lasts two ticks. Wait states are always added as whole bus clocks, and the strobe timing differs between reads and writes.

Top module: `seqbus_master`

## Requirements
- R1: After synchronous reset the block is idle: address strobe, both lane strobes and read/write line high, address and data enables low, done low, and the request-ready output high.
- R2: With the acknowledge already low at the first sample, the cycle takes eight ticks (S0 to S7). Done pulses for one tick in the tick after S7, nine ticks after the accepting edge.
- R3: The address enable is low in S0 and high from S1 to the end of the cycle, with the accepted address on the address output.
- R4: The address strobe is low from S2 to S6, including any wait states, and high in S7. It therefore falls only while the address is already valid.
- R5: In a read, the lane strobes fall and rise together with the address strobe.
- R6: In a write, the read/write line is low and write data is driven from S3 to S7. The lane strobes are low from S4 to S6, one bus clock after the address strobe.
- R7: The acknowledge is sampled at the end of S4 and at the end of each wait pair. Each sample without acknowledge or bus error adds two ticks (W1, W2) to the cycle.
- R8: Read data is captured from the data input at the end of S6. It appears on the read-data output together with done and ignores later changes of the data input.
- R9: Lane mask bit 1 enables the upper strobe and bit 0 enables the lower strobe. A strobe whose bit is clear stays high for the whole cycle.
- R10: When the lane mask is 01 in a write, the low byte of the write data is driven on both halves of the data output. Otherwise the write data is driven unchanged.
- R11: A low bus-error input with acknowledge high at a sample moves the cycle straight to S7 with all strobes high. Done then comes one tick later with the error flag set. An acknowledge seen at the same sample wins, and the cycle completes without error.
- R12: The bus clock toggles every tick and is high in S0, S2, S4, W2 and S6. A request is accepted only in idle while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per bus half-clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is accepted at this edge if valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_lanes | input | 2 | Lane mask: bit 1 upper, bit 0 lower |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-tick completion pulse |
| done_err | output | 1 | Completion ended by bus error |
| rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Bus clock |
| bus_addr | output | AW | Address output |
| bus_addr_oe | output | 1 | Address output valid/driven |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw_n | output | 1 | High for read or idle, low for write |
| bus_ustb_n | output | 1 | Upper lane strobe, active low |
| bus_lstb_n | output | 1 | Lower lane strobe, active low |
| bus_dout | output | DW | Write data output |
| bus_dout_oe | output | 1 | Write data drivers enabled |
| bus_din | input | DW | Read data input |
| bus_ack_n | input | 1 | Transfer acknowledge, active low |
| bus_err_n | input | 1 | Bus error, active low |

## Verification
The bench sweeps both directions, all three non-empty lane masks, zero, one and three wait pairs, and both acknowledge and bus-error endings. It compares every output in every tick against a state schedule worked out from the tick count. Reads against writes separate the strobe timing of the two directions. The lane masks expose wrong lane mapping and missing byte replication. The wait counts show whether stretching comes in whole bus clocks. Driving garbage on the data input in S5 and S7 shows whether capture happens exactly at the end of S6. A case with acknowledge and bus error both low pins down their priority.

// File: rtl/seqbus_pkg.sv
package seqbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_S5, ST_S6, ST_S7, ST_W1, ST_W2
  } bus_st_e;

  typedef struct packed {
    logic aoe;
    logic as_n;
    logic rw_n;
    logic doe;
    logic ds_n;
  } drv_t;

  // Pin levels for one half-clock state.
  function automatic drv_t drive_of(bus_st_e s, logic wr);
    drv_t d;
    logic as_lo, wr_win, wr_stb;
    as_lo  = (s inside {ST_S2, ST_S3, ST_S4, ST_W1, ST_W2, ST_S5, ST_S6});
    wr_win = wr && (s inside {ST_S3, ST_S4, ST_W1, ST_W2, ST_S5, ST_S6, ST_S7});
    wr_stb = (s inside {ST_S4, ST_W1, ST_W2, ST_S5, ST_S6});
    d.aoe  = (s != ST_IDLE) && (s != ST_S0);
    d.as_n = !as_lo;
    d.rw_n = !wr_win;
    d.doe  = wr_win;
    d.ds_n = wr ? !wr_stb : !as_lo;
    return d;
  endfunction

endpackage

// File: rtl/seqbus_fsm.sv
module seqbus_fsm
  import seqbus_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    ack_n,
  input  logic    err_n,
  output bus_st_e st_q,
  output bus_st_e st_d,
  output logic    bclk,
  output logic    fin,
  output logic    fin_err
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          err_q;
  logic [CW-1:0] cnt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_S0;
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ST_S4;
      ST_S4, ST_W2: begin
        if (!ack_n)      st_d = ST_S5;
        else if (!err_n) st_d = ST_S7;
        else             st_d = ST_W1;
      end
      ST_W1:   st_d = ST_W2;
      ST_S5:   st_d = ST_S6;
      ST_S6:   st_d = ST_S7;
      ST_S7:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      bclk    <= 1'b0;
      err_q   <= 1'b0;
      fin     <= 1'b0;
      fin_err <= 1'b0;
      cnt     <= '0;
    end else begin
      st_q    <= st_d;
      bclk    <= ~bclk;
      fin     <= (st_q == ST_S7);
      fin_err <= (st_q == ST_S7) && err_q;
      if (start)
        err_q <= 1'b0;
      else if ((st_q == ST_S4 || st_q == ST_W2) && ack_n && !err_n)
        err_q <= 1'b1;
      if (st_d == ST_S0)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  // R2: a cycle ended by acknowledge spends at least S0..S6 before S7
  p_min_len_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_S7 && !err_q) |-> (cnt >= 7));

  // R7: waits come in pairs, so S5 always lands an odd tick after S0
  p_whole_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_S5 && cnt != CNT_MAX) |-> cnt[0]);

  // R12: even states sit in the high half of the bus clock
  p_clk_phase_r12: assert property (@(posedge clk) disable iff (rst)
    (st_q inside {ST_S0, ST_S2, ST_S4, ST_W2, ST_S6}) |-> bclk);

  // R11: bus error path leaves the strobe window directly
  p_err_exit_r11: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_S4 || st_q == ST_W2) && ack_n && !err_n) |=> (st_q == ST_S7));

endmodule

// File: rtl/seqbus_drive.sv
module seqbus_drive
  import seqbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_st_e    st_d,
  input  logic       wr,
  input  logic [1:0] lanes,
  output logic       aoe,
  output logic       as_n,
  output logic       rw_n,
  output logic       doe,
  output logic       ustb_n,
  output logic       lstb_n
);

  drv_t nxt;

  always_comb nxt = drive_of(st_d, wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      aoe    <= 1'b0;
      as_n   <= 1'b1;
      rw_n   <= 1'b1;
      doe    <= 1'b0;
      ustb_n <= 1'b1;
      lstb_n <= 1'b1;
    end else begin
      aoe    <= nxt.aoe;
      as_n   <= nxt.as_n;
      rw_n   <= nxt.rw_n;
      doe    <= nxt.doe;
      ustb_n <= nxt.ds_n | ~lanes[1];
      lstb_n <= nxt.ds_n | ~lanes[0];
    end
  end

  // R4: strobe only falls after the address has been valid for a tick
  p_as_after_addr_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(as_n) |-> (aoe && $past(aoe)));

  // R5: read lane strobes never active without the address strobe
  p_rd_stb_r5: assert property (@(posedge clk) disable iff (rst)
    (rw_n && (!ustb_n || !lstb_n)) |-> !as_n);

  // R6: write strobes only once data has been driven for a tick
  p_wr_stb_r6: assert property (@(posedge clk) disable iff (rst)
    (!rw_n && (!ustb_n || !lstb_n)) |-> (doe && $past(doe)));

  // R9: a cleared lane bit keeps its strobe high
  p_lane_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (!ustb_n |-> lanes[1]) and (!lstb_n |-> lanes[0]));

endmodule

// File: rtl/seqbus_master.sv
module seqbus_master
  import seqbus_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_lanes,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] rdata,
  output logic          bus_clk,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic          bus_as_n,
  output logic          bus_rw_n,
  output logic          bus_ustb_n,
  output logic          bus_lstb_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack_n,
  input  logic          bus_err_n
);

  localparam int HB = DW / 2;

  bus_st_e       st_q, st_d;
  logic          start;
  logic          wr_q;
  logic [1:0]    lanes_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  assign req_ready = (st_q == ST_IDLE) && !bus_clk;
  assign start     = req_valid && req_ready;

  seqbus_fsm #(.CW(CW)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ack_n   (bus_ack_n),
    .err_n   (bus_err_n),
    .st_q    (st_q),
    .st_d    (st_d),
    .bclk    (bus_clk),
    .fin     (done),
    .fin_err (done_err)
  );

  seqbus_drive u_drive (
    .clk    (clk),
    .rst    (rst),
    .st_d   (st_d),
    .wr     (wr_q),
    .lanes  (lanes_q),
    .aoe    (bus_addr_oe),
    .as_n   (bus_as_n),
    .rw_n   (bus_rw_n),
    .doe    (bus_dout_oe),
    .ustb_n (bus_ustb_n),
    .lstb_n (bus_lstb_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      lanes_q <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        wr_q    <= req_write;
        lanes_q <= req_lanes;
        addr_q  <= req_addr;
        wdata_q <= (req_lanes == 2'b01) ? {2{req_wdata[HB-1:0]}} : req_wdata;
      end
      if (st_q == ST_S6 && !wr_q)
        rdata_q <= bus_din;
    end
  end

  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;
  assign rdata    = rdata_q;

  // R10: lower-byte-only write shows the same byte on both halves
  p_lo_dup_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_dout_oe && !bus_lstb_n && bus_ustb_n) |-> (bus_dout[DW-1:HB] == bus_dout[HB-1:0]));

  // R1/R12: idle bus shows read level and no strobe
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_rw_n && bus_as_n && bus_ustb_n && bus_lstb_n && !bus_addr_oe));

  // R3: address held steady while it is enabled
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_oe && $past(bus_addr_oe)) |-> $stable(bus_addr));

  // R2: done is a single-tick pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/seqbus_master_test.sv
module seqbus_master_test;

  localparam int AW = 23;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_lanes;
  logic [DW-1:0] req_wdata;
  logic          done, done_err;
  logic [DW-1:0] rdata;
  logic          bus_clk, bus_addr_oe, bus_as_n, bus_rw_n;
  logic          bus_ustb_n, bus_lstb_n, bus_dout_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_ack_n, bus_err_n;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  seqbus_master #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
    .done(done), .done_err(done_err), .rdata(rdata),
    .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
    .bus_as_n(bus_as_n), .bus_rw_n(bus_rw_n),
    .bus_ustb_n(bus_ustb_n), .bus_lstb_n(bus_lstb_n),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_din(bus_din),
    .bus_ack_n(bus_ack_n), .bus_err_n(bus_err_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // State codes: 0 idle, 1..8 = S0..S7, 9 = W1, 10 = W2
  function automatic int st_at(int k, int n, bit be);
    int last = 5 + 2 * n;
    if (k <= 5) return k;
    if (k <= last) return ((k - 5) % 2 == 1) ? 9 : 10;
    if (be) return (k == last + 1) ? 8 : 0;
    if (k == last + 1) return 6;
    if (k == last + 2) return 7;
    if (k == last + 3) return 8;
    return 0;
  endfunction

  // {bclk, aoe, as_n, rw_n, ustb_n, lstb_n, doe, ready, done}
  function automatic logic [8:0] exp_pins(int k, int c, bit wr, logic [1:0] ln, bit is_end);
    bit as_lo, wr_win, ds_lo;
    as_lo  = (c inside {3, 4, 5, 6, 7, 9, 10});
    wr_win = wr && (c inside {4, 5, 6, 7, 8, 9, 10});
    ds_lo  = wr ? (c inside {5, 6, 7, 9, 10}) : as_lo;
    return {1'(k % 2), 1'(c >= 2), !as_lo, !wr_win,
            !(ds_lo && ln[1]), !(ds_lo && ln[0]), wr_win,
            1'(c == 0 && (k % 2) == 0), 1'(is_end)};
  endfunction

  task automatic run_cycle(input bit wr, input logic [1:0] ln, input int n,
                           input bit be, input bit both, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input logic [DW-1:0] rd);
    int last = 5 + 2 * n;
    int fin_k = be ? last + 2 : last + 4;
    logic [DW-1:0] exp_d;
    exp_d = (ln == 2'b01) ? {wd[7:0], wd[7:0]} : wd;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_lanes = ln; req_wdata = wd;
    for (int k = 1; k <= fin_k; k++) begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = ~wd;
      begin
        int c = st_at(k, n, be);
        logic [8:0] act, ex;
        act = {bus_clk, bus_addr_oe, bus_as_n, bus_rw_n, bus_ustb_n, bus_lstb_n,
               bus_dout_oe, req_ready, done};
        ex  = exp_pins(k, c, wr, ln, k == fin_k);
        chk(act == ex, "R2/R3/R4/R5/R6/R7/R9/R12 pins", {23'd0, act}, {23'd0, ex});
        if (bus_addr_oe) chk(bus_addr == a, "R3 address", {9'd0, bus_addr}, {9'd0, a});
        if (bus_dout_oe) chk(bus_dout == exp_d, "R10 write data", {16'd0, bus_dout}, {16'd0, exp_d});
      end
      if (k == last) begin
        if (be) begin bus_err_n = 1'b0; bus_ack_n = both ? 1'b0 : 1'b1; end
        else begin bus_ack_n = 1'b0; bus_err_n = both ? 1'b0 : 1'b1; end
      end
      if (k == last + 1) bus_din = 16'hDEAD;
      if (k == last + 2) bus_din = rd;
      if (k == last + 3) bus_din = 16'hBEEF;
    end
    chk(done_err == be, "R11 error flag", {31'd0, done_err}, {31'd0, be});
    if (!wr && !be) chk(rdata == rd, "R8 read data", {16'd0, rdata}, {16'd0, rd});
    bus_ack_n = 1'b1; bus_err_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int it = 0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_lanes = 2'b00; req_wdata = '0; bus_din = '0; bus_ack_n = 1'b1; bus_err_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({bus_as_n, bus_rw_n, bus_ustb_n, bus_lstb_n, bus_addr_oe, bus_dout_oe, done, req_ready} == 8'b1111_0001,
        "R1 reset pins",
        {24'd0, bus_as_n, bus_rw_n, bus_ustb_n, bus_lstb_n, bus_addr_oe, bus_dout_oe, done, req_ready},
        32'h000000F1);
    for (int w = 0; w < 2; w++)
      for (int l = 1; l < 4; l++)
        for (int ni = 0; ni < 3; ni++)
          for (int b = 0; b < 2; b++) begin
            int n = (ni == 2) ? 3 : ni;
            logic [AW-1:0] a = AW'(it * 32'h1357 + 2);
            logic [DW-1:0] wd = DW'(it * 16'h3B1 + 16'h5A96);
            logic [DW-1:0] rd = DW'(it * 16'h0F0D + 16'hC3A5);
            run_cycle(w[0], l[1:0], n, b[0], 1'b0, a, wd, rd);
            it++;
          end
    // R11 acknowledge wins over simultaneous bus error
    run_cycle(1'b0, 2'b11, 1, 1'b0, 1'b1, 23'h12345, 16'h0, 16'h7E81);
    // R9 single lanes on reads with no wait
    run_cycle(1'b0, 2'b10, 0, 1'b0, 1'b0, 23'h00042, 16'h0, 16'h9001);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule